// File: doc/BRIEF.md
# Single-Cycle Processor Core

This block is a 32-bit processor core that fetches, decodes, reads operands, executes, accesses data memory and writes back one instruction per clock period. It supports register-register arithmetic and logic, add-immediate, word load and store, branch-if-equal and an absolute jump. It holds the program counter and a 32-entry general register file. Instruction and data memories live outside the core. Both are read combinationally from an address the core drives. The data memory is written on the rising clock edge whenever the core raises its write strobe.

All architectural state (program counter, registers, data memory) changes only on the rising edge that closes the instruction. The next instruction is therefore presented during the following cycle. There is no delay slot, no exception handling and no wait state.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next program counter is 0 and `dmem_we` stays low.
- R2: Opcode 0x00 (bits [31:26]) selects a register operation. The result is written to the register in bits [15:11], using the sources in bits [25:21] (first) and [20:16] (second). Function field bits [5:0] select the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed set-less-than, 0x00 shift the second source left by bits [10:6], 0x02 shift the second source right logically by bits [10:6]. Any other function value writes no register.
- R3: Opcode 0x08 writes the register in bits [20:16] with the first source plus the sign-extended 16-bit immediate from bits [15:0].
- R4: Opcode 0x23 (load) and opcode 0x2B (store) form the byte address `dmem_addr` as the first source plus the sign-extended immediate. Memories index words with address bits [31:2]. A load writes the read word to the register in bits [20:16]. A store drives that register onto `dmem_wdata` with `dmem_we` high.
- R5: Opcode 0x04 compares the two sources. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4. The instruction after the branch is never executed when the branch is taken.
- R6: Opcode 0x02 sets the next PC to the upper 4 PC bits, then bits [25:0], then two zero bits.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: Any opcode not listed above changes no register and no memory, and advances PC by 4.
- R9: Every instruction takes exactly one cycle. Every instruction other than a branch or jump advances PC by 4.
- R10: `dmem_we` is high only during a store instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word read combinationally at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write strobe for the coming edge |
| dmem_rdata | input | 32 | Data word read combinationally at `dmem_addr` |

## Verification
Each instruction's effect is due on the single rising edge that ends its cycle:
- A register result becomes visible to the next instruction.
- A store lands in the data array at that edge.
- The new PC appears on `imem_addr` straight after that edge.

The bench drives reset at falling edges and counts rising edges from reset release. It samples `imem_addr` at the falling edge after edge k, where it must equal 4k until the first branch. A fixed program runs for several operand pairs. The program stores every register result to a reserved data area and ends in a jump-to-self. The bench compares that area against values computed arithmetically once the core has parked.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_JMP  = 6'h02;
    localparam logic [5:0] OP_BEQ  = 6'h04;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_LDW  = 6'h23;
    localparam logic [5:0] OP_STW  = 6'h2B;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;    // write a general register
        logic    dst_rd;    // destination from [15:11] rather than [20:16]
        logic    use_imm;   // second ALU operand is the sign-extended immediate
        logic    load_sel;  // writeback takes the memory word
        logic    mem_we;    // store
        logic    is_beq;
        logic    is_jmp;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);
    logic [5:0] opcode;
    logic [5:0] funct;

    assign opcode = instr[31:26];
    assign funct  = instr[5:0];

    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, load_sel: 1'b0,
                 mem_we: 1'b0, is_beq: 1'b0, is_jmp: 1'b0, alu_op: ALU_ADD};
        case (opcode)
            OP_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_XOR:  ctrl.alu_op = ALU_XOR;
                    FN_NOR:  ctrl.alu_op = ALU_NOR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    FN_SLL:  ctrl.alu_op = ALU_SLL;
                    FN_SRL:  ctrl.alu_op = ALU_SRL;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_LDW: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.load_sel = 1'b1;
            end
            OP_STW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_beq = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JMP:  ctrl.is_jmp = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [4:0]      shamt,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res,
    output logic            zero
);
    always_comb begin
        case (op)
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_XOR: res = opa ^ opb;
            ALU_NOR: res = ~(opa | opb);
            ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
            ALU_SLL: res = opb << shamt;
            ALU_SRL: res = opb >> shamt;
            default: res = opa + opb;
        endcase
    end

    assign zero = (res == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic [AW-1:0]   rsel_a,
    input  logic [AW-1:0]   rsel_b,
    output logic [XLEN-1:0] rdat_a,
    output logic [XLEN-1:0] rdat_b,
    input  logic            wen,
    input  logic [AW-1:0]   wsel,
    input  logic [XLEN-1:0] wdat
);
    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (wen && (wsel != '0)) begin
            regs_d[wsel] = wdat;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rdat_a = (rsel_a == '0) ? '0 : regs_q[rsel_a];
    assign rdat_b = (rsel_b == '0) ? '0 : regs_q[rsel_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int AW    = $clog2(NREG);
    localparam int PC_HI = XLEN - 28;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    ctrl_t           ctrl;
    logic [XLEN-1:0] src_a, src_b, alu_b, alu_res, imm_sx, wb_data, pc_inc;
    logic            alu_zero;
    logic [AW-1:0]   wb_sel;

    sc_decode u_dec (
        .instr (imem_rdata),
        .ctrl  (ctrl)
    );

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rsel_a (imem_rdata[21 +: AW]),
        .rsel_b (imem_rdata[16 +: AW]),
        .rdat_a (src_a),
        .rdat_b (src_b),
        .wen    (ctrl.reg_we & ~rst),
        .wsel   (wb_sel),
        .wdat   (wb_data)
    );

    sc_alu #(.XLEN(XLEN)) u_alu (
        .opa   (src_a),
        .opb   (alu_b),
        .shamt (imem_rdata[10:6]),
        .op    (ctrl.alu_op),
        .res   (alu_res),
        .zero  (alu_zero)
    );

    always_comb begin
        imm_sx  = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};
        alu_b   = ctrl.use_imm ? imm_sx : src_b;
        wb_sel  = ctrl.dst_rd ? imem_rdata[11 +: AW] : imem_rdata[16 +: AW];
        wb_data = ctrl.load_sel ? dmem_rdata : alu_res;
        pc_inc  = st_q.pc + XLEN'(4);

        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctrl.is_jmp) begin
            st_d.pc = {st_q.pc[XLEN-1 -: PC_HI], imem_rdata[25:0], 2'b00};
        end else if (ctrl.is_beq && alu_zero) begin
            st_d.pc = pc_inc + {imm_sx[XLEN-3:0], 2'b00};
        end else begin
            st_d.pc = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = src_b;
    assign dmem_we    = ctrl.mem_we & ~rst;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_rdata,
    input logic            dmem_we,
    input logic [XLEN-1:0] dmem_wdata
);
    logic [5:0]      opc;
    logic [XLEN-1:0] imm_sx;

    assign opc    = imem_rdata[31:26];
    assign imm_sx = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

    p_reset_pc_r1: assert property (@(posedge clk) rst |=> (imem_addr == '0));

    p_reset_no_store_r1: assert property (@(posedge clk) rst |-> !dmem_we);

    p_store_only_r10: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opc == 6'h2B));

    p_zero_reg_store_r7: assert property (@(posedge clk) disable iff (rst)
        (dmem_we && imem_rdata[20:16] == 5'd0) |-> (dmem_wdata == '0));

    p_seq_pc_r9: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'h04 && opc != 6'h02) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    p_branch_pc_r5: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h04) |=> ((imem_addr == $past(imem_addr) + XLEN'(4)) ||
            (imem_addr == $past(imem_addr) + XLEN'(4) + {$past(imm_sx[XLEN-3:0]), 2'b00})));

    p_jump_pc_r6: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h02) |=> (imem_addr[27:0] == {$past(imem_rdata[25:0]), 2'b00}));

    p_pc_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sc_core u_sc_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(int idx);
        return {6'h02, 26'(idx)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_prog();
        for (int i = 0; i < 64; i++) imem[i] = 32'hFC00_0000;
        imem[0]  = enc_i(6'h23, 0, 1, 16'd0);
        imem[1]  = enc_i(6'h23, 0, 2, 16'd4);
        imem[2]  = enc_r(1, 2, 3, 0, 6'h20);
        imem[3]  = enc_r(1, 2, 4, 0, 6'h22);
        imem[4]  = enc_r(1, 2, 5, 0, 6'h24);
        imem[5]  = enc_r(1, 2, 6, 0, 6'h25);
        imem[6]  = enc_r(1, 2, 7, 0, 6'h26);
        imem[7]  = enc_r(1, 2, 8, 0, 6'h27);
        imem[8]  = enc_r(1, 2, 9, 0, 6'h2A);
        imem[9]  = enc_r(0, 2, 10, 5, 6'h00);
        imem[10] = enc_r(0, 1, 11, 7, 6'h02);
        imem[11] = enc_i(6'h08, 1, 12, 16'hFFFD);
        imem[12] = enc_i(6'h08, 1, 0, 16'd55);
        imem[13] = {6'h3F, 5'd1, 5'd3, 16'h1234};
        imem[14] = enc_r(1, 2, 3, 0, 6'h3F);
        imem[15] = enc_i(6'h08, 0, 13, 16'd128);
        imem[16] = enc_i(6'h08, 0, 14, 16'd7);
        imem[17] = enc_i(6'h08, 0, 15, 16'd5);
        imem[18] = enc_i(6'h08, 0, 16, 16'd3);
        for (int k = 0; k < 10; k++) imem[19+k] = enc_i(6'h2B, 0, 3+k, 16'(64 + 4*k));
        imem[29] = enc_i(6'h2B, 0, 0, 16'd104);
        imem[30] = enc_i(6'h2B, 13, 1, 16'hFFF8);
        imem[31] = enc_i(6'h04, 1, 1, 16'd1);
        imem[32] = enc_i(6'h08, 0, 14, 16'd1);
        imem[33] = enc_i(6'h04, 1, 2, 16'd1);
        imem[34] = enc_i(6'h08, 0, 15, 16'd9);
        imem[35] = enc_j(38);
        imem[36] = enc_i(6'h08, 0, 16, 16'd1);
        imem[37] = enc_i(6'h08, 0, 16, 16'd2);
        imem[38] = enc_i(6'h2B, 0, 14, 16'd108);
        imem[39] = enc_i(6'h2B, 0, 15, 16'd112);
        imem[40] = enc_i(6'h2B, 0, 16, 16'd116);
        imem[41] = enc_j(41);
    endtask

    task automatic run_pair(logic [31:0] a, logic [31:0] b);
        logic [31:0] exp [16];
        rst = 1'b1;
        for (int i = 0; i < 64; i++) dmem[i] = 32'hA5A5_0000 + i;
        dmem[0] = a;
        dmem[1] = b;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", imem_addr, 32'd0);
        chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
        for (int k = 1; k <= 50; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 20) chk("R9 one instr per cycle", imem_addr, 32'd80);
            if (k == 32) chk("R5 taken branch skips one", imem_addr, 32'd132);
        end
        chk("R6 jump to self parks pc", imem_addr, 32'd164);
        exp[0]  = a + b;
        exp[1]  = a - b;
        exp[2]  = a & b;
        exp[3]  = a | b;
        exp[4]  = a ^ b;
        exp[5]  = ~(a | b);
        exp[6]  = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        exp[7]  = b << 5;
        exp[8]  = a >> 7;
        exp[9]  = a - 32'd3;
        exp[10] = 32'd0;
        exp[11] = 32'd7;
        exp[12] = (a == b) ? 32'd5 : 32'd9;
        exp[13] = 32'd3;
        exp[14] = a;
        chk("R2 R8 add (unknown op/funct left it)", dmem[16], exp[0]);
        chk("R2 sub", dmem[17], exp[1]);
        chk("R2 and", dmem[18], exp[2]);
        chk("R2 or", dmem[19], exp[3]);
        chk("R2 xor", dmem[20], exp[4]);
        chk("R2 nor", dmem[21], exp[5]);
        chk("R2 slt", dmem[22], exp[6]);
        chk("R2 sll", dmem[23], exp[7]);
        chk("R2 srl", dmem[24], exp[8]);
        chk("R3 addi negative imm", dmem[25], exp[9]);
        chk("R7 r0 stays zero", dmem[26], exp[10]);
        chk("R5 taken beq skipped write", dmem[27], exp[11]);
        chk("R5 beq equal/unequal", dmem[28], exp[12]);
        chk("R6 jump skipped writes", dmem[29], exp[13]);
        chk("R4 store negative offset", dmem[30], exp[14]);
        chk("R10 no stray store", dmem[31], 32'hA5A5_001F);
        chk("R4 load area intact", dmem[2], 32'hA5A5_0002);
    endtask

    initial begin
        load_prog();
        run_pair(32'd5, 32'd3);
        run_pair(32'd3, 32'd5);
        run_pair(32'h8000_0000, 32'd1);
        run_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_pair(32'h7FFF_FFFF, 32'd1);
        run_pair(32'd0, 32'd0);
        run_pair(32'h1234_5678, 32'h0F0F_F0F0);
        run_pair(32'hDEAD_BEEF, 32'h8000_0000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule